// File: doc/BRIEF.md
# Beacon Timing Timer Engine

This block keeps the time base for a wireless MAC. A 64-bit microsecond timestamp advances on every `tick_us` strobe and can be loaded in two 32-bit halves or cleared by a control write. From that timestamp the block takes a 16-bit time-unit count (1 TU = 1024 µs) and a 19-bit count in eighths of a TU. It compares four target timers against these counts: the next beacon target, the DMA beacon alert, the software beacon alert and the end of the announcement window. When a timer equals its count and the engine is enabled, the timer raises a one-cycle event and moves forward by one beacon period.

Software programs the engine through a write port and reads it back through a read port that returns data one cycle later. Reading the low timestamp word captures the high word, so a following high read gives a coherent 64-bit value. A sticky status register gathers the beacon-miss input and the four timer events, and each of its bits is cleared by writing a one to it. A combinational flag reports whether the announcement window and the DMA alert spacing around the next beacon target are still the intended sizes. A timer is advanced only on an exact match, so a timestamp jump can leave it stale, and the flag exposes the drift that results.

Register addresses: 0 timestamp low, 1 timestamp high, 2 next beacon target, 3 DMA alert, 4 software alert, 5 window end, 6 control, 7 status.

Top module: `bcn_timer_engine`

## Requirements
- R1: After reset, the timestamp, all four timers, the control fields and the status bits are zero, no event is raised, and `win_ok` is 0.
- R2: The timestamp grows by one on each clock edge with `tick_us` high, and the carry passes into the upper 32 bits. A write to address 0 loads bits [31:0] and a write to address 1 loads bits [63:32]. A load takes precedence over the tick.
- R3: `rd_data` holds the selected register on the edge after `rd_en`. A read of address 0 returns timestamp bits [31:0] and captures bits [63:32] into a shadow word. A read of address 1 returns that shadow word, even if the timestamp has been loaded since the capture.
- R4: A control write (address 6) sets the beacon period from bits [15:0] and the enable from bit 16. If bit 17 of the same write is one, the timestamp is cleared on that edge.
- R5: The next beacon target (address 2) and the window end (address 5) are 16-bit TU timers compared with timestamp bits [25:10]. The DMA alert (address 3) and the software alert (address 4) are 19-bit eighth-TU timers compared with bits [25:7]. While the engine is enabled and a timer equals its count, its event bit (`evt[0]` to `evt[3]` in address order 2, 3, 4, 5) is high for exactly that cycle. On the next edge the timer advances by the period, or by eight times the period for the alerts.
- R6: A timer advances only on an exact match. If the timestamp is loaded past a timer's value, that timer keeps its value and raises no event until its count wraps around to it again. The TU count wraps from 0xFFFF to 0x0000.
- R7: While the enable is 0, no event is raised and no timer advances, even when a timer equals its count.
- R8: A write to address 2 loads the next beacon target and also sets the window end to that value plus one, modulo 2^16. A later write to address 5 overrides the window end directly.
- R9: Status bit 0 is set by `bmiss_in`, and status bits 1 to 4 are set by `evt[0]` to `evt[3]`. A write to address 7 clears exactly those status bits whose write-data bit is one and leaves the others unchanged.
- R10: `win_ok` is 1 when two spacing checks both pass. The first compares A = next beacon target with B = window end, using a window of 1. The second compares A = DMA alert bits [18:3] with B = next beacon target, using a window of `DMA_RESP_TU` (default 2). A check passes when any of these holds: B−A = w; A−B = P−w; (A+2^16)−B = P−w; (B+2^16)−A = w. Here P is the period and the arithmetic is signed integer arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond strobe that advances the timestamp |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid on the edge after `rd_en` |
| bmiss_in | input | 1 | Beacon-miss event, sets status bit 0 |
| evt | output | 4 | Timer match events (next beacon, DMA alert, software alert, window end) |
| sts | output | 5 | Sticky status, bits cleared by writing ones |
| win_ok | output | 1 | Timer spacing consistency flag |

## Verification
A wrong timer value does not show at once. It shows as an event that arrives at a different cycle count than the one computed from the loaded timestamp, or as a missing or extra event one full period later. For that reason the scoreboard checks the exact cycle of every event over two consecutive periods, and after a timestamp jump it checks that a timer which was passed stays silent. A wrong timestamp or shadow word shows on the next read, one cycle after `rd_en`. A timer left stale or advanced wrongly shows at once on `win_ok`, because the flag is combinational.

// File: rtl/bte_pkg.sv
`timescale 1ns/1ps
package bte_pkg;

    typedef enum logic [2:0] {
        ADR_TSF_LO = 3'd0,
        ADR_TSF_HI = 3'd1,
        ADR_NBT    = 3'd2,
        ADR_DBA    = 3'd3,
        ADR_SBA    = 3'd4,
        ADR_ATIM   = 3'd5,
        ADR_CTRL   = 3'd6,
        ADR_STS    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [15:0] period;
        logic        run;
    } ctl_t;

    // Register address that loads timer index i.
    function automatic logic [2:0] tmr_addr(input int i);
        case (i)
            0:       return ADR_NBT;
            1:       return ADR_DBA;
            2:       return ADR_SBA;
            default: return ADR_ATIM;
        endcase
    endfunction

    // Spacing test between two wrapping timers a (earlier) and b (later).
    function automatic logic gap_fits(input int a, input int b, input int w,
                                      input int per, input int span);
        return ((b - a) == w) ||
               ((a - b) == (per - w)) ||
               (((a + span) - b) == (per - w)) ||
               (((b + span) - a) == w);
    endfunction

endpackage

// File: rtl/bte_tsf.sv
`timescale 1ns/1ps
module bte_tsf #(
    parameter int TSF_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  clr,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [TSF_W/2-1:0]    ld_data,
    input  logic                  rd_lo,
    output logic [TSF_W-1:0]      tsf,
    output logic [TSF_W/2-1:0]    shadow
);
    localparam int HALF = TSF_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            tsf    <= '0;
            shadow <= '0;
        end else begin
            if (clr) begin
                tsf <= '0;
            end else if (ld_lo || ld_hi) begin
                if (ld_lo) tsf[HALF-1:0]     <= ld_data;
                if (ld_hi) tsf[TSF_W-1:HALF] <= ld_data;
            end else if (tick) begin
                tsf <= tsf + 1'b1;
            end
            if (rd_lo) shadow <= tsf[TSF_W-1:HALF];
        end
    end
endmodule

// File: rtl/bte_target.sv
`timescale 1ns/1ps
module bte_target #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] step,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         fire
);
    assign fire = run && (val == cnt);

    always_ff @(posedge clk) begin
        if (rst)       val <= '0;
        else if (ld)   val <= ld_val;
        else if (fire) val <= val + step;
    end
endmodule

// File: rtl/bte_window.sv
`timescale 1ns/1ps
module bte_window
    import bte_pkg::*;
#(
    parameter int TW          = 16,
    parameter int FRAC        = 3,
    parameter int DMA_RESP_TU = 2
) (
    input  logic [TW-1:0]      nbt,
    input  logic [TW-1:0]      atim,
    input  logic [TW+FRAC-1:0] dba,
    input  logic [TW-1:0]      period,
    output logic               ok
);
    localparam int SPAN = 1 << TW;

    logic [TW-1:0] dba_tu;
    logic          atim_fit, dba_fit;

    assign dba_tu = dba[TW+FRAC-1:FRAC];

    always_comb begin
        atim_fit = gap_fits(int'(nbt), int'(atim), 1, int'(period), SPAN);
        dba_fit  = gap_fits(int'(dba_tu), int'(nbt), DMA_RESP_TU, int'(period), SPAN);
        ok       = atim_fit && dba_fit;
    end
endmodule

// File: rtl/bcn_timer_engine.sv
`timescale 1ns/1ps
module bcn_timer_engine
    import bte_pkg::*;
#(
    parameter int TW          = 16,
    parameter int FRAC        = 3,
    parameter int TU_LSB      = 10,
    parameter int DMA_RESP_TU = 2,
    parameter int TSF_W       = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_us,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [TSF_W/2-1:0]   wr_data,
    input  logic                 rd_en,
    input  logic [2:0]           rd_addr,
    output logic [TSF_W/2-1:0]   rd_data,
    input  logic                 bmiss_in,
    output logic [3:0]           evt,
    output logic [4:0]           sts,
    output logic                 win_ok
);
    localparam int AW   = TW + FRAC;
    localparam int DW   = TSF_W / 2;
    localparam int NT   = 4;
    localparam int SW   = NT + 1;
    localparam int RUNB = TW;
    localparam int CLRB = TW + 1;

    ctl_t              ctl_q;
    logic [TSF_W-1:0]  tsf_q;
    logic [DW-1:0]     tsf_shadow;
    logic [TW-1:0]     tu_cnt;
    logic [AW-1:0]     fr_cnt;
    logic [AW-1:0]     tmr_q [NT];
    logic [SW-1:0]     sts_q;
    logic              tsf_clr;

    function automatic logic wr_hit(input logic [2:0] a);
        return wr_en && (wr_addr == a);
    endfunction

    // Control register
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_hit(ADR_CTRL)) begin
            ctl_q.period <= wr_data[TW-1:0];
            ctl_q.run    <= wr_data[RUNB];
        end
    end

    assign tsf_clr = wr_hit(ADR_CTRL) && wr_data[CLRB];

    bte_tsf #(.TSF_W(TSF_W)) u_tsf (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_us),
        .clr     (tsf_clr),
        .ld_lo   (wr_hit(ADR_TSF_LO)),
        .ld_hi   (wr_hit(ADR_TSF_HI)),
        .ld_data (wr_data),
        .rd_lo   (rd_en && (rd_addr == ADR_TSF_LO)),
        .tsf     (tsf_q),
        .shadow  (tsf_shadow)
    );

    assign tu_cnt = tsf_q[TU_LSB+TW-1:TU_LSB];
    assign fr_cnt = tsf_q[TU_LSB+TW-1:TU_LSB-FRAC];

    // Target timers: 0 and 3 in TU, 1 and 2 in eighth-TU
    for (genvar i = 0; i < NT; i++) begin : g_tmr
        if (i == 1 || i == 2) begin : g_frac
            logic [AW-1:0] val;
            bte_target #(.W(AW)) u_t (
                .clk    (clk),
                .rst    (rst),
                .run    (ctl_q.run),
                .cnt    (fr_cnt),
                .step   ({ctl_q.period, {FRAC{1'b0}}}),
                .ld     (wr_hit(tmr_addr(i))),
                .ld_val (wr_data[AW-1:0]),
                .val    (val),
                .fire   (evt[i])
            );
            assign tmr_q[i] = val;
        end else begin : g_tu
            logic [TW-1:0] val;
            logic          ld;
            logic [TW-1:0] ld_val;
            if (i == NT - 1) begin : g_end
                // window end: direct write, or seeded from next-target write
                assign ld     = wr_hit(ADR_ATIM) || wr_hit(ADR_NBT);
                assign ld_val = wr_hit(ADR_ATIM) ? wr_data[TW-1:0]
                                                 : wr_data[TW-1:0] + 1'b1;
            end else begin : g_plain
                assign ld     = wr_hit(tmr_addr(i));
                assign ld_val = wr_data[TW-1:0];
            end
            bte_target #(.W(TW)) u_t (
                .clk    (clk),
                .rst    (rst),
                .run    (ctl_q.run),
                .cnt    (tu_cnt),
                .step   (ctl_q.period),
                .ld     (ld),
                .ld_val (ld_val),
                .val    (val),
                .fire   (evt[i])
            );
            assign tmr_q[i] = AW'(val);
        end
    end

    // Sticky status, write-one-to-clear per bit
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~(wr_hit(ADR_STS) ? wr_data[SW-1:0] : '0))
                     | {evt, bmiss_in};
        end
    end
    assign sts = sts_q;

    // Read port, one cycle latency
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                ADR_TSF_LO: rd_data <= tsf_q[DW-1:0];
                ADR_TSF_HI: rd_data <= tsf_shadow;
                ADR_NBT:    rd_data <= DW'(tmr_q[0]);
                ADR_DBA:    rd_data <= DW'(tmr_q[1]);
                ADR_SBA:    rd_data <= DW'(tmr_q[2]);
                ADR_ATIM:   rd_data <= DW'(tmr_q[3]);
                ADR_CTRL:   rd_data <= DW'({ctl_q.run, ctl_q.period});
                default:    rd_data <= DW'(sts_q);
            endcase
        end
    end

    bte_window #(.TW(TW), .FRAC(FRAC), .DMA_RESP_TU(DMA_RESP_TU)) u_win (
        .nbt    (tmr_q[0][TW-1:0]),
        .atim   (tmr_q[3][TW-1:0]),
        .dba    (tmr_q[1]),
        .period (ctl_q.period),
        .ok     (win_ok)
    );
endmodule

// File: rtl/bcn_timer_engine_chk.sv
`timescale 1ns/1ps
module bcn_timer_engine_chk #(
    parameter int TW    = 16,
    parameter int AW    = 19,
    parameter int TSF_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_us,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic              bmiss_in,
    input logic [3:0]        evt,
    input logic [4:0]        sts,
    input logic [TSF_W-1:0]  tsf,
    input logic [AW-1:0]     t0,
    input logic [TW-1:0]     period,
    input logic              run
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (tsf == '0 && sts == '0 && t0 == '0 && !run));

    // R2
    tsf_counts_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_us && !(wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1 ||
                                (wr_addr == 3'd6 && wr_data[TW+1]))))
        |=> tsf == $past(tsf) + 1'b1);

    // R4
    tsf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd6 && wr_data[TW+1]) |=> tsf == '0);

    // R5
    target_step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt[0] && !(wr_en && wr_addr == 3'd2))
        |=> t0[TW-1:0] == TW'($past(t0[TW-1:0]) + $past(period)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> evt == 4'b0000);

    // R9
    miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd7 && wr_data[0] && !bmiss_in) |=> !sts[0]);
endmodule

bind bcn_timer_engine bcn_timer_engine_chk #(.TW(TW), .AW(AW), .TSF_W(TSF_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick_us  (tick_us),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bmiss_in (bmiss_in),
    .evt      (evt),
    .sts      (sts),
    .tsf      (tsf_q),
    .t0       (tmr_q[0]),
    .period   (ctl_q.period),
    .run      (ctl_q.run)
);

// File: tb/bcn_timer_engine_tb.sv
`timescale 1ns/1ps
module bcn_timer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        bmiss_in = 1'b0;
    logic [3:0]  evt;
    logic [4:0]  sts;
    logic        win_ok;

    int     errs = 0;
    int     chks = 0;
    longint cyc  = 0;

    typedef struct { int ch; longint at; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bcn_timer_engine dut_i (
        .clk(clk), .rst(rst), .tick_us(tick_us),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .bmiss_in(bmiss_in), .evt(evt), .sts(sts), .win_ok(win_ok)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic push(input int ch, input longint at);
        exp_t e;
        e.ch = ch; e.at = at;
        exp_q.push_back(e);
    endtask

    task automatic run_ticks(input int n);
        tick_us = 1'b1;
        repeat (n) @(negedge clk);
        tick_us = 1'b0;
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R5 pending events at end", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    endtask

    // Monitor: compare every event against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 4; c++) begin
                if (evt[c]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5/R6/R7 unexpected event ch", c, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.ch == c, "R5 event channel", c, e.ch);
                        check(e.at == cyc, "R5 event cycle", cyc, e.at);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        longint base;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(sts == 5'd0, "R1 status", sts, 0);
        check(evt == 4'd0, "R1 events", evt, 0);
        check(win_ok == 1'b0, "R1 win_ok", win_ok, 0);
        rd(3'd0, d); check(d == 0, "R1 tsf low", d, 0);
        rd(3'd2, d); check(d == 0, "R1 next target", d, 0);

        // R2 load and carry
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'h0000_0007);
        rd(3'd0, d); check(d == 32'hFFFF_FFF0, "R2 load low", d, 32'hFFFF_FFF0);
        rd(3'd1, d); check(d == 32'h7, "R2 load high", d, 7);
        @(negedge clk);
        run_ticks(20);
        // R3 shadow coherence
        rd(3'd0, d); check(d == 32'h4, "R2 low after carry", d, 4);
        wr(3'd1, 32'h55);
        rd(3'd1, d); check(d == 32'h8, "R3 shadow keeps captured high", d, 8);
        rd(3'd0, d);
        rd(3'd1, d); check(d == 32'h55, "R3 shadow after new capture", d, 32'h55);

        // R5/R8 main timer run: period 10 TU, DMA window 2 TU
        wr(3'd1, 32'h0);
        wr(3'd0, 32'd102000);
        wr(3'd3, 32'd797);
        wr(3'd4, 32'd798);
        wr(3'd2, 32'd101);
        rd(3'd5, d); check(d == 32'd102, "R8 window end seeded", d, 102);
        wr(3'd6, 32'h0001_000A);
        check(win_ok == 1'b1, "R10 aligned timers", win_ok, 1);
        @(negedge clk);
        base = cyc;
        push(1, base + 16);    push(2, base + 144);
        push(0, base + 1424);  push(3, base + 2448);
        push(1, base + 10256); push(2, base + 10384);
        push(0, base + 11664); push(3, base + 12688);
        run_ticks(12700);
        check(win_ok == 1'b1, "R10 after two periods", win_ok, 1);
        rd(3'd0, d); rd(3'd2, d); check(d == 32'd121, "R5 next target advanced", d, 121);
        rd(3'd3, d); check(d == 32'd957, "R5 DMA alert advanced by 8x", d, 957);

        // R6 jump past the alerts leaves them stale
        wr(3'd6, 32'h0000_000A);
        wr(3'd0, 32'd122980);
        wr(3'd6, 32'h0001_000A);
        @(negedge clk);
        base = cyc;
        push(0, base + 924); push(3, base + 1948);
        run_ticks(2000);
        rd(3'd3, d); check(d == 32'd957, "R6 stale DMA alert", d, 957);
        check(win_ok == 1'b0, "R10 drift flagged", win_ok, 0);

        // R6 TU count wrap
        wr(3'd6, 32'h0000_000A);
        wr(3'd1, 32'h5);
        wr(3'd0, 32'h03FF_FF9C);
        wr(3'd2, 32'h0);
        wr(3'd6, 32'h0001_000A);
        @(negedge clk);
        base = cyc;
        push(0, base + 100);
        run_ticks(150);
        rd(3'd2, d); check(d == 32'd10, "R6 match across wrap", d, 10);
        rd(3'd0, d); check(d == 32'h0400_0032, "R2 low after wrap run", d, 32'h0400_0032);
        rd(3'd1, d); check(d == 32'h5, "R3 high after wrap run", d, 5);

        // R7 disabled: matching timer stays put
        wr(3'd6, 32'h0000_000A);
        wr(3'd2, 32'h0);
        @(negedge clk);
        run_ticks(10);
        rd(3'd2, d); check(d == 32'd0, "R7 no advance while disabled", d, 0);
        wr(3'd5, 32'h1234);
        rd(3'd5, d); check(d == 32'h1234, "R8 direct window end", d, 32'h1234);

        // R10 wrap-around spacing
        wr(3'd2, 32'hFFFF);
        wr(3'd3, 32'h7FFE8);
        check(win_ok == 1'b1, "R10 spacing across wrap", win_ok, 1);

        // R9 status
        check(sts == 5'h1E, "R9 event status bits", sts, 5'h1E);
        @(negedge clk); bmiss_in = 1'b1;
        @(negedge clk); bmiss_in = 1'b0;
        check(sts == 5'h1F, "R9 beacon miss set", sts, 5'h1F);
        wr(3'd7, 32'h1);
        check(sts == 5'h1E, "R9 clear miss only", sts, 5'h1E);
        wr(3'd7, 32'h1E);
        check(sts == 5'h00, "R9 clear event bits", sts, 0);

        // R4 timestamp clear
        wr(3'd6, 32'h0002_0000);
        rd(3'd0, d); check(d == 0, "R4 tsf low cleared", d, 0);
        rd(3'd1, d); check(d == 0, "R4 tsf high cleared", d, 0);
        rd(3'd6, d); check(d == 0, "R4 control fields", d, 0);

        finish_run();
    end
endmodule